// File: doc/BRIEF.md
# Status Flag Update Unit

This unit owns the processor's condition flags and computes their next value after each ALU operation. Six flags are held: zero, negative, carry, overflow, overflow-trap and sticky. An instruction's decoded class supplies a 3-bit update mode for every flag. The unit applies each mode to the raw values that come with the ALU result: the result word, the carry-out, the overflow and the sticky bit. The new flags are registered and take effect one clock after an operation is presented.

The registered carry is also driven back to the ALU as its carry input. Two 16-bit operations can then be chained into a 32-bit add, or into a 32-bit subtract where carry means "no borrow". During such a chain the zero flag uses the clear-only mode, so it ends up set only when every word of the result was zero. Add, subtract and compare set the flags in the same way for signed and unsigned operands. From the registered flags the unit decodes an unsigned set of branch conditions (higher, lower-or-same) and a signed set (greater-than, less-or-equal, greater-or-equal, less-than), plus equal and not-equal.

Mode 110 marks a flag as undefined after the operation. The hardware keeps the previous value, but software must not rely on that value, and the bench never checks it.

Top module: `flag_update_unit`

## Requirements
- R1: After reset all six flags read 0. The flag vector `flags_q` holds zero in bit 0, negative in bit 1, carry in bit 2, overflow in bit 3, overflow-trap in bit 4 and sticky in bit 5.
- R2: A cycle with `op_valid` low leaves `flags_q` unchanged. So does mode 000 (hold) for the flag it applies to.
- R3: With mode 001 (update), the flag in the following cycle takes its raw value: zero = result is all zeros, negative = result MSB, carry = `op_carry`, overflow = `op_ovf`, overflow-trap = `op_ovf`, sticky = `op_sticky`.
- R4: Mode 010 forces the flag to 0 and mode 011 forces it to 1, whatever the raw value. The mode for flag i is `op_modes[3i+2:3i]`.
- R5: Mode 100 (set-only) gives the old flag OR the raw value. A set flag is never cleared by it.
- R6: Mode 101 (clear-only) gives the old flag AND the raw value. A clear flag is never set by it.
- R7: `alu_carry_in` equals the registered carry flag. When a chained add or subtract runs with zero in clear-only mode, zero ends set only if every word of the result was zero.
- R8: The overflow-trap flag, in set-only mode, becomes 1 after any operation with `op_ovf` high. It stays 1 through later operations without overflow until a mode-010 operation clears it.
- R9: `br_higher` = carry AND NOT zero, and `br_lower_same` is its complement. Both follow the registered flags.
- R10: `br_ge` = (negative == overflow), `br_lt` is its complement, `br_gt` = `br_ge` AND NOT zero, and `br_le` is the complement of `br_gt`.
- R11: `br_eq` equals the zero flag and `br_ne` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_result | input | W | ALU result word |
| op_carry | input | 1 | Raw carry-out (no borrow for subtract) |
| op_ovf | input | 1 | Raw signed overflow |
| op_sticky | input | 1 | Raw sticky bit from shifts |
| op_modes | input | 18 | Six 3-bit update modes, flag i at bits 3i+2:3i |
| flags_q | output | 6 | Registered flags {ST,VT,V,C,N,Z} |
| alu_carry_in | output | 1 | Carry fed to the ALU for chained operations |
| br_higher | output | 1 | Unsigned higher |
| br_lower_same | output | 1 | Unsigned lower or same |
| br_gt | output | 1 | Signed greater-than |
| br_le | output | 1 | Signed less-or-equal |
| br_ge | output | 1 | Signed greater-or-equal |
| br_lt | output | 1 | Signed less-than |
| br_eq | output | 1 | Equal (zero set) |
| br_ne | output | 1 | Not equal |

## Verification
The assertions assume that every mode field carries one of the seven defined codes whenever `op_valid` is high. They also assume that the raw carry, overflow and sticky inputs are consistent with the result word, as a real ALU would produce them. The stimulus computes results, carries and overflows in a small 16-bit add and subtract model inside the bench, so the raw inputs always match the result word. It only ever drives defined mode codes. Undefined mode appears only on flags that a following operation forces back to a known value, so no check depends on an unspecified flag.

// File: rtl/flag_update_unit.sv
module flag_update_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [W-1:0] op_result,
  input  logic         op_carry,
  input  logic         op_ovf,
  input  logic         op_sticky,
  input  logic [17:0]  op_modes,
  output logic [5:0]   flags_q,
  output logic         alu_carry_in,
  output logic         br_higher,
  output logic         br_lower_same,
  output logic         br_gt,
  output logic         br_le,
  output logic         br_ge,
  output logic         br_lt,
  output logic         br_eq,
  output logic         br_ne
);
  localparam int NF = 6;
  localparam int ZB = 0, NB = 1, CB = 2, VB = 3;

  logic [NF-1:0] raw, nxt;

  assign raw = {op_sticky, op_ovf, op_ovf, op_carry, op_result[W-1], ~|op_result};

  for (genvar f = 0; f < NF; f++) begin : g_flag
    logic [2:0] md;
    assign md = op_modes[3*f +: 3];
    always_comb begin
      case (md)
        3'b001:  nxt[f] = raw[f];
        3'b010:  nxt[f] = 1'b0;
        3'b011:  nxt[f] = 1'b1;
        3'b100:  nxt[f] = flags_q[f] | raw[f];
        3'b101:  nxt[f] = flags_q[f] & raw[f];
        default: nxt[f] = flags_q[f];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (op_valid) flags_q <= nxt;
  end

  assign alu_carry_in  = flags_q[CB];
  assign br_eq         = flags_q[ZB];
  assign br_ne         = ~flags_q[ZB];
  assign br_higher     = flags_q[CB] & ~flags_q[ZB];
  assign br_lower_same = ~br_higher;
  assign br_ge         = ~(flags_q[NB] ^ flags_q[VB]);
  assign br_lt         = ~br_ge;
  assign br_gt         = br_ge & ~flags_q[ZB];
  assign br_le         = ~br_gt;
endmodule

// File: rtl/flag_update_chk.sv
module flag_update_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [W-1:0] op_result,
  input logic         op_ovf,
  input logic [17:0]  op_modes,
  input logic [5:0]   flags_q
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags_q)); // R2
  AST_ZERO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_modes[2:0] == 3'b001 |=> flags_q[0] == $past(op_result == '0)); // R3
  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_modes[2:0] == 3'b011 |=> flags_q[0]); // R4
  AST_SET_ONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_modes[8:6] == 3'b100 && flags_q[2] |=> flags_q[2]); // R5
  AST_CLEAR_ONLY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_modes[2:0] == 3'b101 && !flags_q[0] |=> !flags_q[0]); // R6
  AST_TRAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ovf && op_modes[14:12] == 3'b100 |=> flags_q[4]); // R8
endmodule

bind flag_update_unit flag_update_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_result(op_result),
  .op_ovf(op_ovf), .op_modes(op_modes), .flags_q(flags_q)
);

// File: tb/tb_flag_update_unit.sv
module tb_flag_update_unit;
  localparam int W = 16;
  localparam logic [2:0] HLD = 3'b000, UPD = 3'b001, F0 = 3'b010, F1 = 3'b011,
                         SO = 3'b100, CO = 3'b101, UND = 3'b110;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_carry = 0, op_ovf = 0, op_sticky = 0;
  logic [W-1:0] op_result = '0;
  logic [17:0] op_modes = '0;
  logic [5:0] flags_q;
  logic alu_carry_in, br_higher, br_lower_same, br_gt, br_le, br_ge, br_lt, br_eq, br_ne;

  flag_update_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_result(op_result),
    .op_carry(op_carry), .op_ovf(op_ovf), .op_sticky(op_sticky), .op_modes(op_modes),
    .flags_q(flags_q), .alu_carry_in(alu_carry_in), .br_higher(br_higher),
    .br_lower_same(br_lower_same), .br_gt(br_gt), .br_le(br_le), .br_ge(br_ge),
    .br_lt(br_lt), .br_eq(br_eq), .br_ne(br_ne));

  always #4 clk = ~clk;

  typedef struct { logic [5:0] f; logic [5:0] known; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic [5:0] exp_f = '0, known = 6'h3f;
  logic pending = 0;
  logic [W-1:0] res_lo;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [2:0] z, n, c, v, vt, st);
    return {st, vt, v, c, n, z};
  endfunction

  function automatic logic model(input logic [2:0] m, input logic cur, input logic raw);
    case (m)
      UPD: return raw;
      F0:  return 1'b0;
      F1:  return 1'b1;
      SO:  return cur | raw;
      CO:  return cur & raw;
      default: return cur;
    endcase
  endfunction

  task automatic op(input string req, input logic [W-1:0] r, input logic c, v, st,
                    input logic [17:0] m);
    item_t it;
    logic [5:0] raw;
    raw = {st, v, v, c, r[W-1], (r == '0)};
    for (int i = 0; i < 6; i++) begin
      exp_f[i] = model(m[3*i +: 3], exp_f[i], raw[i]);
      if (m[3*i +: 3] == UND) known[i] = 1'b0;
      else if (m[3*i +: 3] != HLD) known[i] = known[i] & (m[3*i +: 3] != SO && m[3*i +: 3] != CO) | known[i] | (m[3*i +: 3] == F0 || m[3*i +: 3] == F1);
    end
    it.f = exp_f; it.known = known; it.req = req;
    q.push_back(it);
    op_result = r; op_carry = c; op_ovf = v; op_sticky = st; op_modes = m;
    op_valid = 1; pending = 1;
    @(negedge clk);
  endtask

  task automatic idle(input string req, input logic [17:0] m);
    item_t it;
    it.f = exp_f; it.known = known; it.req = req;
    q.push_back(it);
    op_valid = 0; op_modes = m; op_result = '0; op_carry = 1; op_ovf = 1; op_sticky = 1;
    pending = 1;
    @(negedge clk);
  endtask

  task automatic arith(input string req, input logic [W-1:0] a, b, input logic sub,
                       input logic cin, input logic [17:0] m);
    logic [W:0] s;
    logic [W-1:0] bb;
    logic v;
    bb = sub ? ~b : b;
    s = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};
    v = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
    op(req, s[W-1:0], s[W], v, 1'b0, m);
  endtask

  logic due = 0;
  always @(posedge clk) due <= pending;
  always @(negedge clk) begin
    #1;
    if (due && q.size() > 0) begin
      item_t it;
      logic z, n, c, v, ge;
      it = q.pop_front();
      chk({it.req, " flags"}, {2'b0, flags_q & it.known}, {2'b0, it.f & it.known});
      z = it.f[0]; n = it.f[1]; c = it.f[2]; v = it.f[3];
      if (it.known[2]) chk("R7 carry to ALU", {7'b0, alu_carry_in}, {7'b0, c});
      if (it.known[0] && it.known[2])
        chk("R9 unsigned branches", {6'b0, br_higher, br_lower_same}, {6'b0, c & ~z, ~(c & ~z)});
      ge = (n == v);
      if (it.known[0] && it.known[1] && it.known[3])
        chk("R10 signed branches", {4'b0, br_gt, br_le, br_ge, br_lt},
            {4'b0, ge & ~z, ~(ge & ~z), ge, ~ge});
      if (it.known[0]) chk("R11 equality branches", {6'b0, br_eq, br_ne}, {6'b0, z, ~z});
    end
  end

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] ar, ac, alll;
    ar = mk(UPD, UPD, UPD, UPD, SO, HLD);
    ac = mk(CO, UPD, UPD, UPD, SO, HLD);
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {2'b0, flags_q}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags after release", {2'b0, flags_q}, 8'h00);
    // R3 update from raw values
    op("R3", 16'h0000, 1, 0, 1, mk(UPD, UPD, UPD, UPD, UPD, UPD));
    op("R3", 16'h8001, 0, 1, 0, mk(UPD, UPD, UPD, UPD, UPD, UPD));
    // R2 idle and hold mode
    idle("R2", mk(F1, F1, F1, F1, F1, F1));
    op("R2", 16'h0000, 1, 0, 0, mk(HLD, HLD, HLD, HLD, HLD, HLD));
    // R4 forcing
    op("R4", 16'h1234, 0, 0, 0, mk(F1, F0, F1, F0, F0, F1));
    op("R4", 16'h0000, 1, 1, 0, mk(F0, F1, F0, F1, F1, F0));
    // R5 set-only: set flag stays, clear flag sets on raw
    op("R5", 16'h0001, 0, 0, 0, mk(SO, SO, SO, SO, SO, SO));
    op("R5", 16'h0000, 1, 0, 1, mk(F0, F0, SO, F0, F0, SO));
    // R6 clear-only
    op("R6", 16'h0000, 1, 0, 0, mk(F1, F1, F1, F1, F0, F1));
    op("R6", 16'h0000, 1, 1, 1, mk(CO, CO, CO, CO, HLD, CO));
    op("R6", 16'h0005, 0, 0, 0, mk(CO, CO, CO, CO, HLD, CO));
    op("R6", 16'h0000, 1, 1, 1, mk(CO, CO, CO, CO, HLD, CO));
    // R8 overflow trap latch and clear
    op("R8", 16'h0000, 0, 0, 0, mk(F0, F0, F0, F0, F0, F0));
    arith("R8", 16'h7fff, 16'h0001, 0, 0, ar);
    arith("R8", 16'h0001, 16'h0001, 0, 0, ar);
    arith("R8", 16'h0003, 16'h0001, 1, 1, ar);
    op("R8", 16'h0001, 0, 0, 0, mk(HLD, HLD, HLD, HLD, F0, HLD));
    // R7 chained 32-bit adds: 0x0001_0000 + 0xffff_0000 = 0 (mod 2^32)
    arith("R7", 16'h0000, 16'h0000, 0, 0, ar);
    arith("R7", 16'h0001, 16'hffff, 0, exp_f[2], ac);
    // 0x0000_0001 + 0x0000_ffff = 0x0001_0000 : low zero, carry into high, nonzero
    arith("R7", 16'h0001, 16'hffff, 0, 0, ar);
    arith("R7", 16'h0000, 16'h0000, 0, exp_f[2], ac);
    // chained 32-bit subtract: 0x0002_0005 - 0x0001_0005 = 0x0001_0000
    arith("R7", 16'h0005, 16'h0005, 1, 1, ar);
    arith("R7", 16'h0002, 16'h0001, 1, exp_f[2], ac);
    // chained subtract equal operands 0x1234_5678 - 0x1234_5678 = 0
    arith("R7", 16'h5678, 16'h5678, 1, 1, ar);
    arith("R7", 16'h1234, 16'h1234, 1, exp_f[2], ac);
    // R9 R10 compares across signed/unsigned patterns
    arith("R9", 16'h0005, 16'h0003, 1, 1, ar);
    arith("R9", 16'h0003, 16'h0005, 1, 1, ar);
    arith("R10", 16'hfffe, 16'h0001, 1, 1, ar);
    arith("R10", 16'h0001, 16'hfffe, 1, 1, ar);
    arith("R10", 16'h8000, 16'h0001, 1, 1, ar);
    arith("R11", 16'h4444, 16'h4444, 1, 1, ar);
    // undefined mode, then forced back to known values
    op("R2", 16'h0000, 1, 1, 1, mk(UND, UND, UND, UND, UND, UND));
    known = 6'h3f;
    op("R4", 16'h0000, 0, 0, 0, mk(F0, F1, F1, F0, F0, F1));
    idle("R2", '0);
    pending = 0;
    repeat (4) @(negedge clk);
    if (q.size() != 0) chk("R2 scoreboard drained", 8'(q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule